// File: doc/BRIEF.md
# Shared-Pointer Display Memory Port

This block gives a host bus access to three small on-chip memories through one auto-incrementing pointer. The memories are an 80-byte character code store, a 48-entry glyph pattern store (6 glyphs of 8 rows, 5 pixels per row) and a 20-byte icon store holding 160 icon bits. An address-set instruction picks the memory and loads the pointer. Every data transfer then works on the byte at the pointer and moves the pointer on by one. When the pointer passes the last entry of the selected memory, it wraps to zero.

Reads are pipelined through an output register. A data read returns what the register already holds. The register is then refilled from the pointer and the pointer advances. The register is not reloaded by an address set, so the first read after one returns stale data. The host treats that read as a dummy.

The bus works in 8-bit mode or in 4-bit mode. In 4-bit mode every byte takes two strobes on the upper four data lines.

Top module: `disp_ram_port`

## Requirements
- R1: After reset, the pointer is 0 and selects the character memory, the output register holds 0, `dout` is 0, and the next 4-bit strobe is taken as the first nibble.
- R2: An instruction write (`is_data`=0) decodes the byte as follows. Pattern `1aaaaaaa` selects character memory at address a. Pattern `01aaaaaa` selects glyph memory at address a. Pattern `001aaaaa` selects icon memory at address a. An address at or beyond the selected memory's size (80, 48 or 20) loads 0. Pattern `000xxxxx` changes nothing.
- R3: A data write stores the byte at the pointer in the selected memory, and the pointer then advances by one.
- R4: Reads and writes advance the pointer from the last entry (79, 47 or 19) to entry 0 of the same memory.
- R5: A data read returns the output register and then refills it from the pointer while the pointer advances. In 8-bit mode, the first read after an address set therefore returns the previous register value.
- R6: The glyph memory keeps bits [4:0] of a written byte. Bits [7:5] read back as 0.
- R7: In 4-bit mode a byte is sent on `din[7:4]`, high nibble first and then low nibble. It takes effect on the second strobe.
- R8: In 4-bit mode, `dout[7:4]` carries the low nibble of the output register on the first strobe of a read and the high nibble on the second. `dout[3:0]` is 0. The first two nibble reads after an address set are dummies.
- R9: A read strobe with `is_data`=0 leaves the pointer and the output register unchanged.
- R10: A write to one memory leaves the contents of the other two unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nibble_mode | input | 1 | 1 selects the 4-bit bus, 0 selects the 8-bit bus |
| wr_en | input | 1 | Write strobe, one cycle per transfer |
| rd_en | input | 1 | Read strobe, one cycle per transfer (ignored when `wr_en` is 1) |
| is_data | input | 1 | 1 selects a data transfer, 0 selects an instruction |
| din | input | 8 | Write byte (upper four bits in 4-bit mode) |
| dout | output | 8 | Read byte, or the current nibble on [7:4] in 4-bit mode |

## Verification
The assertions check, on every cycle:
- the pointer stays inside the selected memory's size;
- every data transfer moves the pointer by exactly one step with wrap;
- an address set loads the decoded address;
- the output register changes only on a data read, and a glyph fetch clears its upper bits;
- the low half of `dout` is silent in 4-bit mode.

Only the bench scenarios can show that stored bytes land at the right address and memory. Those scenarios also show that dummy reads return the earlier register value, that nibbles come in the right order, and that writes to one memory leave the others intact. They do this by filling and rereading all three memories in both bus modes.

// File: rtl/dram_pkg.sv
package dram_pkg;

  localparam int PTR_W = 7;

  typedef enum logic [1:0] {
    TGT_CHAR  = 2'd0,
    TGT_GLYPH = 2'd1,
    TGT_ICON  = 2'd2
  } tgt_e;

  typedef struct packed {
    logic             hit;
    tgt_e             tgt;
    logic [PTR_W-1:0] ptr;
  } aset_t;

  // Size of the memory a target names.
  function automatic int unsigned lim_of(tgt_e t, int unsigned cl, int unsigned gl,
                                         int unsigned il);
    case (t)
      TGT_GLYPH: return gl;
      TGT_ICON:  return il;
      default:   return cl;
    endcase
  endfunction

  // Pointer step with wrap at the memory size.
  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p, int unsigned lim);
    int unsigned n;
    n = int'(p) + 1;
    if (n >= lim) return '0;
    return PTR_W'(n);
  endfunction

  // Address-set decode. Out-of-range addresses load zero.
  function automatic aset_t aset_decode(logic [7:0] b, int unsigned cl, int unsigned gl,
                                        int unsigned il);
    aset_t r;
    r.hit = 1'b1;
    r.tgt = TGT_CHAR;
    r.ptr = '0;
    if (b[7]) begin
      r.tgt = TGT_CHAR;
      r.ptr = b[6:0];
    end else if (b[6]) begin
      r.tgt = TGT_GLYPH;
      r.ptr = {1'b0, b[5:0]};
    end else if (b[5]) begin
      r.tgt = TGT_ICON;
      r.ptr = {2'b00, b[4:0]};
    end else begin
      r.hit = 1'b0;
    end
    if (int'(r.ptr) >= lim_of(r.tgt, cl, gl, il)) r.ptr = '0;
    return r;
  endfunction

endpackage

// File: rtl/bus_nibbler.sv
module bus_nibbler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nibble_mode,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] din,
  output logic       phase,
  output logic       beat_done,
  output logic [7:0] beat_byte
);

  logic [3:0] hi_q;
  logic       strobe;

  assign strobe    = wr_en | rd_en;
  assign beat_done = strobe & (~nibble_mode | phase);
  assign beat_byte = nibble_mode ? {hi_q, din[7:4]} : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      hi_q  <= '0;
    end else if (!nibble_mode) begin
      phase <= 1'b0;
    end else if (strobe) begin
      phase <= ~phase;
      if (!phase) hi_q <= din[7:4];
    end
  end

endmodule

// File: rtl/addr_ptr.sv
module addr_ptr
  import dram_pkg::*;
#(
  parameter int unsigned CHAR_LIM  = 80,
  parameter int unsigned GLYPH_LIM = 48,
  parameter int unsigned ICON_LIM  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       instr,
  input  logic             step,
  output tgt_e             tgt_q,
  output logic [PTR_W-1:0] ptr_q
);

  aset_t dec;
  assign dec = aset_decode(instr, CHAR_LIM, GLYPH_LIM, ICON_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= TGT_CHAR;
      ptr_q <= '0;
    end else if (load) begin
      if (dec.hit) begin
        tgt_q <= dec.tgt;
        ptr_q <= dec.ptr;
      end
    end else if (step) begin
      ptr_q <= ptr_next(ptr_q, lim_of(tgt_q, CHAR_LIM, GLYPH_LIM, ICON_LIM));
    end
  end

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
  parameter int DEPTH = 80,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/disp_ram_port.sv
module disp_ram_port
  import dram_pkg::*;
#(
  parameter int CHAR_DEPTH  = 80,
  parameter int GLYPH_CHARS = 6,
  parameter int GLYPH_ROWS  = 8,
  parameter int GLYPH_BITS  = 5,
  parameter int ICON_BITS   = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nibble_mode,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       is_data,
  input  logic [7:0] din,
  output logic [7:0] dout
);

  localparam int GLYPH_DEPTH = GLYPH_CHARS * GLYPH_ROWS;
  localparam int ICON_DEPTH  = ICON_BITS / 8;
  localparam int CAW = $clog2(CHAR_DEPTH);
  localparam int GAW = $clog2(GLYPH_DEPTH);
  localparam int IAW = $clog2(ICON_DEPTH);

  // Named internal events
  logic             phase;
  logic             beat_done;
  logic [7:0]       beat_byte;
  logic             addr_set;
  logic             data_wr;
  logic             data_rd;
  tgt_e             tgt;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       out_q;
  logic [7:0]       fetch_byte;

  logic [7:0]            char_rd;
  logic [GLYPH_BITS-1:0] glyph_rd;
  logic [7:0]            icon_rd;

  assign addr_set = beat_done & wr_en & ~is_data;
  assign data_wr  = beat_done & wr_en & is_data;
  assign data_rd  = beat_done & ~wr_en & rd_en & is_data;

  bus_nibbler u_nib (
    .clk         (clk),
    .rst_n       (rst_n),
    .nibble_mode (nibble_mode),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .din         (din),
    .phase       (phase),
    .beat_done   (beat_done),
    .beat_byte   (beat_byte)
  );

  addr_ptr #(
    .CHAR_LIM  (CHAR_DEPTH),
    .GLYPH_LIM (GLYPH_DEPTH),
    .ICON_LIM  (ICON_DEPTH)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (addr_set),
    .instr (beat_byte),
    .step  (data_wr | data_rd),
    .tgt_q (tgt),
    .ptr_q (ptr)
  );

  ram_bank #(.DEPTH(CHAR_DEPTH), .WIDTH(8), .AW(CAW)) u_char (
    .clk   (clk),
    .we    (data_wr && tgt == TGT_CHAR),
    .addr  (ptr[CAW-1:0]),
    .wdata (beat_byte),
    .rdata (char_rd)
  );

  ram_bank #(.DEPTH(GLYPH_DEPTH), .WIDTH(GLYPH_BITS), .AW(GAW)) u_glyph (
    .clk   (clk),
    .we    (data_wr && tgt == TGT_GLYPH),
    .addr  (ptr[GAW-1:0]),
    .wdata (beat_byte[GLYPH_BITS-1:0]),
    .rdata (glyph_rd)
  );

  ram_bank #(.DEPTH(ICON_DEPTH), .WIDTH(8), .AW(IAW)) u_icon (
    .clk   (clk),
    .we    (data_wr && tgt == TGT_ICON),
    .addr  (ptr[IAW-1:0]),
    .wdata (beat_byte),
    .rdata (icon_rd)
  );

  always_comb begin
    case (tgt)
      TGT_GLYPH: fetch_byte = {{(8-GLYPH_BITS){1'b0}}, glyph_rd};
      TGT_ICON:  fetch_byte = icon_rd;
      default:   fetch_byte = char_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (data_rd) out_q <= fetch_byte;
  end

  always_comb begin
    if (nibble_mode) dout = {(phase ? out_q[7:4] : out_q[3:0]), 4'b0000};
    else             dout = out_q;
  end

endmodule

// File: rtl/disp_ram_port_chk.sv
module disp_ram_port_chk
  import dram_pkg::*;
#(
  parameter int unsigned CHAR_LIM  = 80,
  parameter int unsigned GLYPH_LIM = 48,
  parameter int unsigned ICON_LIM  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nibble_mode,
  input logic [7:0]       dout,
  input logic             phase,
  input logic [7:0]       beat_byte,
  input logic             addr_set,
  input logic             data_wr,
  input logic             data_rd,
  input tgt_e             tgt,
  input logic [PTR_W-1:0] ptr,
  input logic [7:0]       out_q
);

  aset_t dec;
  assign dec = aset_decode(beat_byte, CHAR_LIM, GLYPH_LIM, ICON_LIM);

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < lim_of(tgt, CHAR_LIM, GLYPH_LIM, ICON_LIM)); // R4

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || data_rd) |=>
      (ptr == ptr_next($past(ptr), lim_of($past(tgt), CHAR_LIM, GLYPH_LIM, ICON_LIM))
       && tgt == $past(tgt))); // R3

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_set && dec.hit) |=> (ptr == $past(dec.ptr) && tgt == $past(dec.tgt))); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(out_q)); // R9

  AST_GLYPH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && tgt == TGT_GLYPH) |=> (out_q[7:5] == 3'b000)); // R6

  AST_NIBBLE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    nibble_mode |-> (dout[3:0] == 4'b0000)); // R8

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !nibble_mode |=> !phase); // R7

endmodule

bind disp_ram_port disp_ram_port_chk #(
  .CHAR_LIM  (CHAR_DEPTH),
  .GLYPH_LIM (GLYPH_DEPTH),
  .ICON_LIM  (ICON_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nibble_mode (nibble_mode),
  .dout        (dout),
  .phase       (phase),
  .beat_byte   (beat_byte),
  .addr_set    (addr_set),
  .data_wr     (data_wr),
  .data_rd     (data_rd),
  .tgt         (tgt),
  .ptr         (ptr),
  .out_q       (out_q)
);

// File: tb/test_disp_ram_port.sv
module test_disp_ram_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nibble_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       is_data = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;

  // Reference model: 0 char, 1 glyph, 2 icon
  int m_char [80];
  int m_glyph [48];
  int m_icon [20];
  int m_tgt = 0;
  int m_ptr = 0;
  int m_out = 0;

  always #5 clk = ~clk;

  disp_ram_port i_disp_ram_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .nibble_mode (nibble_mode),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .is_data     (is_data),
    .din         (din),
    .dout        (dout)
  );

  function automatic int size_of(int t);
    return (t == 1) ? 48 : (t == 2) ? 20 : 80;
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One bus strobe; dout is sampled while the strobe is held, before the edge.
  task automatic strobe(input bit w, input bit d, input logic [7:0] v, output logic [7:0] s);
    @(negedge clk);
    wr_en = w; rd_en = !w; is_data = d; din = v;
    #1 s = dout;
    @(posedge clk);
    #1 wr_en = 0; rd_en = 0;
  endtask

  task automatic send(input bit d, input logic [7:0] b);
    logic [7:0] s;
    if (nibble_mode) begin
      strobe(1'b1, d, {b[7:4], 4'h0}, s);
      strobe(1'b1, d, {b[3:0], 4'h0}, s);
    end else begin
      strobe(1'b1, d, b, s);
    end
  endtask

  task automatic do_instr(input logic [7:0] b);
    int a;
    send(1'b0, b);
    if (b[7] || b[6] || b[5]) begin
      m_tgt = b[7] ? 0 : b[6] ? 1 : 2;
      a = b[7] ? int'(b[6:0]) : b[6] ? int'(b[5:0]) : int'(b[4:0]);
      m_ptr = (a >= size_of(m_tgt)) ? 0 : a;
    end
  endtask

  task automatic do_write(input logic [7:0] b);
    send(1'b1, b);
    case (m_tgt)
      1: m_glyph[m_ptr] = int'(b) & 8'h1F;
      2: m_icon[m_ptr] = int'(b);
      default: m_char[m_ptr] = int'(b);
    endcase
    m_ptr = (m_ptr + 1) % size_of(m_tgt);
  endtask

  task automatic do_read(input string tag);
    logic [7:0] s1, s2;
    if (nibble_mode) begin
      strobe(1'b0, 1'b1, 8'h00, s1);
      check(s1 == {m_out[3:0], 4'h0}, tag, s1, {m_out[3:0], 4'h0});
      strobe(1'b0, 1'b1, 8'h00, s2);
      check(s2 == {m_out[7:4], 4'h0}, tag, s2, {m_out[7:4], 4'h0});
    end else begin
      strobe(1'b0, 1'b1, 8'h00, s1);
      check(s1 == m_out[7:0], tag, s1, m_out);
    end
    case (m_tgt)
      1: m_out = m_glyph[m_ptr];
      2: m_out = m_icon[m_ptr];
      default: m_out = m_char[m_ptr];
    endcase
    m_ptr = (m_ptr + 1) % size_of(m_tgt);
  endtask

  task automatic instr_read();
    logic [7:0] s;
    strobe(1'b0, 1'b0, 8'h00, s);
    if (nibble_mode) strobe(1'b0, 1'b0, 8'h00, s);
  endtask

  task automatic read_all(input int t, input string tag);
    do_instr(t == 0 ? 8'h80 : t == 1 ? 8'h40 : 8'h20);
    do_read("R5 dummy");
    for (int i = 0; i < size_of(t); i++) do_read(tag);
    do_read("R4 read wrap");
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(dout == 8'h00, "R1 reset dout", dout, 0);
    rst_n = 1'b1;
    // R1: first read after reset returns the cleared register
    do_read("R1 reset register");

    // 8-bit fills of all three memories
    do_instr(8'h80);
    for (int i = 0; i < 80; i++) do_write(8'((i * 7 + 3) & 8'hFF));
    do_write(8'hC3); // R4: wraps to character entry 0
    do_instr(8'h40);
    for (int i = 0; i < 48; i++) do_write(8'((i * 13 + 5) | 8'hE0)); // R6 upper bits set
    do_instr(8'h20);
    for (int i = 0; i < 20; i++) do_write(8'((i * 29 + 1) & 8'hFF));
    read_all(0, "R3 char data");
    read_all(1, "R6 glyph data");
    read_all(2, "R10 icon data");

    // R2: out-of-range addresses load zero
    do_instr(8'hE4); do_write(8'hA5);
    do_instr(8'h7F); do_write(8'h5A);
    do_instr(8'h3F); do_write(8'h3C);
    read_all(0, "R2 char clamp");
    read_all(1, "R2 glyph clamp");
    read_all(2, "R2 icon clamp");

    // R2: 000xxxxx instructions change nothing
    do_instr(8'h85);
    do_instr(8'h13);
    do_instr(8'h1F);
    do_write(8'h77);
    do_instr(8'h85);
    do_read("R5 dummy");
    do_read("R2 no-op instr");

    // R9: instruction reads leave pointer and register alone
    do_instr(8'h8A);
    do_read("R5 dummy");
    instr_read();
    do_read("R9 instr read");
    instr_read();
    do_read("R9 instr read");

    // R4: write wrap at the top of glyph and icon memories
    do_instr(8'h6F); do_write(8'h11); do_write(8'h12);
    do_instr(8'h33); do_write(8'h21); do_write(8'h22);
    read_all(1, "R4 glyph wrap");
    read_all(2, "R4 icon wrap");

    // 4-bit bus
    nibble_mode = 1'b1;
    do_instr(8'hA8); // char 40
    for (int i = 0; i < 10; i++) do_write(8'((i * 37 + 9) & 8'hFF));
    do_instr(8'hA8);
    do_read("R8 nibble dummy");
    for (int i = 0; i < 10; i++) do_read("R7 R8 nibble data");
    do_instr(8'h20);
    for (int i = 0; i < 20; i++) do_write(8'((i * 53 + 17) & 8'hFF));
    read_all(2, "R8 nibble icon");
    do_instr(8'h40);
    for (int i = 0; i < 48; i++) do_write(8'((i * 11 + 2) & 8'hFF));
    read_all(1, "R6 nibble glyph");
    instr_read();
    do_read("R9 nibble instr read");

    // Back to 8-bit: R10 full re-read of every memory
    nibble_mode = 1'b0;
    read_all(0, "R10 char intact");
    read_all(1, "R10 glyph intact");
    read_all(2, "R10 icon intact");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule